// File: doc/BRIEF.md
# RV32I Decode-Stage Control Generator

This block sits in the decode stage of a five-stage integer pipeline. It looks at three fields of the instruction word: the 7-bit major opcode, the 3-bit minor function field and the 7-bit upper function field. From them it derives, with no clock and no state, every control bit that the execute, memory and write-back stages carry forward.

The outputs are:
- separate flags for the direct jump and the register-indirect jump;
- a register write-back mode that also encodes the width and sign of a load;
- a select that routes loaded data to the register file;
- a four-lane byte store mask;
- a select that routes the return address (PC+4) to the result;
- a two-bit mark of which source registers are really read, for the forwarding unit;
- a branch condition code;
- an ALU operation code;
- the two ALU operand selects;
- the immediate layout code.

An opcode the block does not know, or a function-field combination that is not legal, produces inactive outputs only. Such an instruction then behaves as a bubble.

Top module: `rv_decode_ctl`

## Requirements
- R1: All outputs are a pure function of the opcode, minor-function and upper-function inputs; a given input triple always gives the same outputs. With all inputs zero, every output is zero.
- R2: `jal_o` is 1 only for opcode 1101111. `jalr_o` is 1 only for opcode 1100111 with minor function 000. The two are never 1 together.
- R3: For opcode 0100011, `store_mask_o` depends on the minor function: 000 gives 0001, 001 gives 0011 and 010 gives 1111. All other minor-function values, and all other opcodes, give 0000.
- R4: `mem_to_reg_o` is 1 only for a legal load (opcode 0000011). `load_npc_o` is 1 exactly when `jal_o` or `jalr_o` is 1.
- R5: `wb_mode_o` encodes the write-back as follows:
  - 0: no write.
  - 1: full 32-bit word. Used for the word load (minor 010), for register and immediate arithmetic, and for opcodes 0110111, 0010111 and both jumps.
  - 2: signed byte load (minor 000).
  - 3: signed halfword load (minor 001).
  - 4: unsigned byte load (minor 100).
  - 5: unsigned halfword load (minor 101).
  - Stores, branches and illegal encodings give 0.
- R6: `reg_read_o` bit 1 marks that rs1 is read and bit 0 that rs2 is read.
  - 11: register-register arithmetic, stores and branches.
  - 10: immediate arithmetic, loads and the indirect jump.
  - 00: opcodes 0110111, 0010111, 1101111, and illegal encodings.
- R7: For opcode 1100011, `branch_o` depends on the minor function: 000 gives 1 (equal), 001 gives 2 (not equal), 100 gives 3 (less, signed), 101 gives 4 (greater or equal, signed), 110 gives 5 (less, unsigned) and 111 gives 6 (greater or equal, unsigned). Minor 010 and 011, and all other opcodes, give 0.
- R8: `alu_op_o` codes are 0 add, 1 sub, 2 shift left, 3 set-less signed, 4 set-less unsigned, 5 xor, 6 logical right shift, 7 arithmetic right shift, 8 or, 9 and, 10 pass operand 2.
  - For opcodes 0110011 and 0010011 the minor function selects: 000 add, 001 sll, 010 slt, 011 sltu, 100 xor, 101 right shift, 110 or, 111 and.
  - Upper-function bit 5 turns add into sub for 0110011 only, and turns the right shift into the arithmetic one for both opcodes.
  - Opcode 0110111 gives 10. Every other opcode gives 0.
- R9: `src1_pc_o` is 1 only for opcode 0010111. `src2_sel_o` is 0 (rs2) for 0110011, branches and illegal encodings; 2 (shift amount) for 0010011 with minor 001 or 101; and 1 (immediate) otherwise.
- R10: `imm_fmt_o` is 0 for none, 1 for I, 2 for S, 3 for B, 4 for U and 5 for J. The I layout covers 0010011, loads and the indirect jump. U covers 0110111 and 0010111.
- R11: The following are illegal and give all outputs zero:
  - an opcode outside the nine listed;
  - a load with minor 011, 110 or 111;
  - a store with minor above 010;
  - a branch with minor 010 or 011;
  - an indirect jump with minor other than 000;
  - 0110011 with an upper function other than 0000000, or 0100000 paired with minor 000 or 101;
  - 0010011 shifts whose upper function is not 0000000 (left shift) or not in {0000000, 0100000} (right shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 7 | Major opcode field |
| f3_i | input | 3 | Minor function field |
| f7_i | input | 7 | Upper function field |
| jal_o | output | 1 | Direct jump in decode |
| jalr_o | output | 1 | Register-indirect jump in decode |
| wb_mode_o | output | 3 | Write-back mode / load width and sign |
| mem_to_reg_o | output | 1 | Write loaded data to the register file |
| store_mask_o | output | 4 | Byte-lane store mask |
| load_npc_o | output | 1 | Route PC+4 to the result |
| reg_read_o | output | 2 | rs1 read (bit 1), rs2 read (bit 0) |
| branch_o | output | 3 | Branch condition code |
| alu_op_o | output | 4 | ALU operation code |
| src1_pc_o | output | 1 | ALU operand 1 is the PC |
| src2_sel_o | output | 2 | ALU operand 2: rs2, immediate, shift amount |
| imm_fmt_o | output | 3 | Immediate layout code |

## Verification
Several controls rise together for one instruction, and the overlap that matters most is the jump. A jump must raise its jump flag, the return-address select and a word write-back in the same evaluation, while the load-data select stays low. The store is the other overlap: a non-zero lane mask appears with both register-read bits set and no write-back. The bench provokes both cases as part of an exhaustive sweep over every opcode, minor-function and upper-function value. After each vector it compares every output against a model built from the requirement tables, so a missing or extra control in either overlap is reported on its own field.

// File: rtl/rvd_pkg.sv
package rvd_pkg;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;
  localparam int WB_W   = 3;
  localparam int BR_W   = 3;
  localparam int ALU_W  = 4;
  localparam int IMM_W  = 3;
  localparam int SRC2_W = 2;
  localparam int LANES  = 4;
  localparam int LANE_CNT_W = $clog2(LANES) + 1;
  localparam int F7_ALT_BIT = 5;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    CL_NONE, CL_LOAD, CL_OPIMM, CL_AUIPC, CL_STORE,
    CL_OP, CL_LUI, CL_BRANCH, CL_JALR, CL_JAL
  } icls_e;

  typedef enum logic [WB_W-1:0] {
    WB_NONE = 3'd0, WB_WORD = 3'd1, WB_SB = 3'd2, WB_SH = 3'd3,
    WB_UB = 3'd4, WB_UH = 3'd5
  } wb_e;

  typedef enum logic [BR_W-1:0] {
    BR_NONE = 3'd0, BR_EQ = 3'd1, BR_NE = 3'd2, BR_LT = 3'd3,
    BR_GE = 3'd4, BR_LTU = 3'd5, BR_GEU = 3'd6
  } br_e;

  typedef enum logic [ALU_W-1:0] {
    AL_ADD = 4'd0, AL_SUB = 4'd1, AL_SLL = 4'd2, AL_SLT = 4'd3,
    AL_SLTU = 4'd4, AL_XOR = 4'd5, AL_SRL = 4'd6, AL_SRA = 4'd7,
    AL_OR = 4'd8, AL_AND = 4'd9, AL_PASS2 = 4'd10
  } alu_e;

  typedef enum logic [SRC2_W-1:0] {
    S2_REG = 2'd0, S2_IMM = 2'd1, S2_SHAMT = 2'd2
  } src2_e;

  typedef enum logic [IMM_W-1:0] {
    IF_NONE = 3'd0, IF_I = 3'd1, IF_S = 3'd2, IF_B = 3'd3,
    IF_U = 3'd4, IF_J = 3'd5
  } immf_e;
endpackage

// File: rtl/rvd_classify.sv
module rvd_classify
  import rvd_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [F7_W-1:0]  f7_i,
  output icls_e            cls_o
);
  logic legal;
  icls_e raw;

  always_comb begin
    raw   = CL_NONE;
    legal = 1'b0;
    unique case (op_i)
      OPC_LOAD: begin
        raw   = CL_LOAD;
        legal = (f3_i != 3'd3) && (f3_i != 3'd6) && (f3_i != 3'd7);
      end
      OPC_STORE: begin
        raw   = CL_STORE;
        legal = (f3_i <= 3'd2);
      end
      OPC_BRANCH: begin
        raw   = CL_BRANCH;
        legal = (f3_i != 3'd2) && (f3_i != 3'd3);
      end
      OPC_JALR: begin
        raw   = CL_JALR;
        legal = (f3_i == 3'd0);
      end
      OPC_OPIMM: begin
        raw = CL_OPIMM;
        if (f3_i == 3'd1)      legal = (f7_i == F7_BASE);
        else if (f3_i == 3'd5) legal = (f7_i == F7_BASE) || (f7_i == F7_ALT);
        else                   legal = 1'b1;
      end
      OPC_OP: begin
        raw = CL_OP;
        legal = (f7_i == F7_BASE) ||
                ((f7_i == F7_ALT) && ((f3_i == 3'd0) || (f3_i == 3'd5)));
      end
      OPC_LUI:   begin raw = CL_LUI;   legal = 1'b1; end
      OPC_AUIPC: begin raw = CL_AUIPC; legal = 1'b1; end
      OPC_JAL:   begin raw = CL_JAL;   legal = 1'b1; end
      default:   begin raw = CL_NONE;  legal = 1'b0; end
    endcase
    cls_o = legal ? raw : CL_NONE;
  end
endmodule

// File: rtl/rvd_alu_ctl.sv
module rvd_alu_ctl
  import rvd_pkg::*;
(
  input  icls_e            cls_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [F7_W-1:0]  f7_i,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             src1_pc_o,
  output logic [SRC2_W-1:0] src2_sel_o
);
  logic  alt;
  alu_e  arith;
  logic  is_arith;

  assign alt      = f7_i[F7_ALT_BIT];
  assign is_arith = (cls_i == CL_OP) || (cls_i == CL_OPIMM);

  always_comb begin
    unique case (f3_i)
      3'd0:    arith = (alt && (cls_i == CL_OP)) ? AL_SUB : AL_ADD;
      3'd1:    arith = AL_SLL;
      3'd2:    arith = AL_SLT;
      3'd3:    arith = AL_SLTU;
      3'd4:    arith = AL_XOR;
      3'd5:    arith = alt ? AL_SRA : AL_SRL;
      3'd6:    arith = AL_OR;
      default: arith = AL_AND;
    endcase
  end

  always_comb begin
    if (is_arith)              alu_op_o = arith;
    else if (cls_i == CL_LUI)  alu_op_o = AL_PASS2;
    else                       alu_op_o = AL_ADD;
  end

  assign src1_pc_o = (cls_i == CL_AUIPC);

  always_comb begin
    unique case (cls_i)
      CL_NONE, CL_OP, CL_BRANCH: src2_sel_o = S2_REG;
      CL_OPIMM: src2_sel_o = ((f3_i == 3'd1) || (f3_i == 3'd5)) ? S2_SHAMT : S2_IMM;
      default:  src2_sel_o = S2_IMM;
    endcase
  end
endmodule

// File: rtl/rvd_mem_wb.sv
module rvd_mem_wb
  import rvd_pkg::*;
(
  input  icls_e            cls_i,
  input  logic [F3_W-1:0]  f3_i,
  output logic [WB_W-1:0]  wb_mode_o,
  output logic             mem_to_reg_o,
  output logic [LANES-1:0] store_mask_o,
  output logic             load_npc_o,
  output logic             jal_o,
  output logic             jalr_o,
  output logic [BR_W-1:0]  branch_o
);
  logic [LANE_CNT_W-1:0] lanes;
  logic is_store;

  assign is_store = (cls_i == CL_STORE);
  assign lanes    = is_store ? (LANE_CNT_W'(1) << f3_i[1:0]) : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign store_mask_o[g] = (LANE_CNT_W'(g) < lanes);
  end

  assign jal_o        = (cls_i == CL_JAL);
  assign jalr_o       = (cls_i == CL_JALR);
  assign load_npc_o   = (cls_i == CL_JAL) || (cls_i == CL_JALR);
  assign mem_to_reg_o = (cls_i == CL_LOAD);

  always_comb begin
    unique case (cls_i)
      CL_LOAD: begin
        unique case (f3_i)
          3'd0:    wb_mode_o = WB_SB;
          3'd1:    wb_mode_o = WB_SH;
          3'd4:    wb_mode_o = WB_UB;
          3'd5:    wb_mode_o = WB_UH;
          default: wb_mode_o = WB_WORD;
        endcase
      end
      CL_OP, CL_OPIMM, CL_LUI, CL_AUIPC, CL_JAL, CL_JALR: wb_mode_o = WB_WORD;
      default: wb_mode_o = WB_NONE;
    endcase
  end

  always_comb begin
    branch_o = BR_NONE;
    if (cls_i == CL_BRANCH) begin
      unique case (f3_i)
        3'd0:    branch_o = BR_EQ;
        3'd1:    branch_o = BR_NE;
        3'd4:    branch_o = BR_LT;
        3'd5:    branch_o = BR_GE;
        3'd6:    branch_o = BR_LTU;
        3'd7:    branch_o = BR_GEU;
        default: branch_o = BR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rvd_operand_ctl.sv
module rvd_operand_ctl
  import rvd_pkg::*;
(
  input  icls_e            cls_i,
  output logic [1:0]       reg_read_o,
  output logic [IMM_W-1:0] imm_fmt_o
);
  always_comb begin
    unique case (cls_i)
      CL_OP:                      begin reg_read_o = 2'b11; imm_fmt_o = IF_NONE; end
      CL_STORE:                   begin reg_read_o = 2'b11; imm_fmt_o = IF_S;    end
      CL_BRANCH:                  begin reg_read_o = 2'b11; imm_fmt_o = IF_B;    end
      CL_OPIMM, CL_LOAD, CL_JALR: begin reg_read_o = 2'b10; imm_fmt_o = IF_I;    end
      CL_LUI, CL_AUIPC:           begin reg_read_o = 2'b00; imm_fmt_o = IF_U;    end
      CL_JAL:                     begin reg_read_o = 2'b00; imm_fmt_o = IF_J;    end
      default:                    begin reg_read_o = 2'b00; imm_fmt_o = IF_NONE; end
    endcase
  end
endmodule

// File: rtl/rv_decode_ctl.sv
module rv_decode_ctl
  import rvd_pkg::*;
(
  input  logic [6:0] op_i,
  input  logic [2:0] f3_i,
  input  logic [6:0] f7_i,
  output logic       jal_o,
  output logic       jalr_o,
  output logic [2:0] wb_mode_o,
  output logic       mem_to_reg_o,
  output logic [3:0] store_mask_o,
  output logic       load_npc_o,
  output logic [1:0] reg_read_o,
  output logic [2:0] branch_o,
  output logic [3:0] alu_op_o,
  output logic       src1_pc_o,
  output logic [1:0] src2_sel_o,
  output logic [2:0] imm_fmt_o
);
  icls_e cls;

  rvd_classify u_cls (
    .op_i (op_i), .f3_i (f3_i), .f7_i (f7_i), .cls_o (cls)
  );

  rvd_alu_ctl u_alu (
    .cls_i (cls), .f3_i (f3_i), .f7_i (f7_i),
    .alu_op_o (alu_op_o), .src1_pc_o (src1_pc_o), .src2_sel_o (src2_sel_o)
  );

  rvd_mem_wb u_mwb (
    .cls_i (cls), .f3_i (f3_i),
    .wb_mode_o (wb_mode_o), .mem_to_reg_o (mem_to_reg_o),
    .store_mask_o (store_mask_o), .load_npc_o (load_npc_o),
    .jal_o (jal_o), .jalr_o (jalr_o), .branch_o (branch_o)
  );

  rvd_operand_ctl u_opd (
    .cls_i (cls), .reg_read_o (reg_read_o), .imm_fmt_o (imm_fmt_o)
  );

  // Cross-checks between outputs produced by separate submodules.
  always_comb begin
    assert_jump_excl_R2: assert (!(jal_o && jalr_o))
      else $error("both jump flags raised");
    assert_store_quiet_R3: assert ((store_mask_o == '0) ||
                                   (wb_mode_o == WB_NONE && reg_read_o == 2'b11 && imm_fmt_o == IF_S))
      else $error("store mask with write-back or wrong operand use");
    assert_npc_jump_R4: assert (!load_npc_o || (wb_mode_o == WB_WORD && !mem_to_reg_o && alu_op_o == AL_ADD))
      else $error("return-address select without word write-back");
    assert_load_mode_R5: assert (!mem_to_reg_o || (wb_mode_o != WB_NONE && imm_fmt_o == IF_I))
      else $error("load select without a load write mode");
    assert_branch_quiet_R7: assert ((branch_o == BR_NONE) ||
                                    (wb_mode_o == WB_NONE && store_mask_o == '0 && src2_sel_o == S2_REG))
      else $error("branch with write-back or store");
    assert_shamt_src_R9: assert ((src2_sel_o != S2_SHAMT) || (reg_read_o == 2'b10 && imm_fmt_o == IF_I))
      else $error("shift amount select outside immediate shifts");
  end
endmodule

// File: tb/sim_rv_decode_ctl.sv
module sim_rv_decode_ctl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [6:0] op;
  logic [2:0] f3;
  logic [6:0] f7;
  logic jal, jalr, m2r, npc, s1pc;
  logic [2:0] wb, br, immf;
  logic [3:0] mask, alu;
  logic [1:0] rr, s2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rv_decode_ctl u0 (
    .op_i (op), .f3_i (f3), .f7_i (f7),
    .jal_o (jal), .jalr_o (jalr), .wb_mode_o (wb), .mem_to_reg_o (m2r),
    .store_mask_o (mask), .load_npc_o (npc), .reg_read_o (rr),
    .branch_o (br), .alu_op_o (alu), .src1_pc_o (s1pc),
    .src2_sel_o (s2), .imm_fmt_o (immf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s op=%b f3=%b f7=%b actual=%0d expected=%0d",
               req, what, op, f3, f7, act, exp);
    end
  endtask

  // Reference model built from the requirement tables.
  task automatic model(input int o, input int a, input int b,
                       output int e_jal, output int e_jalr, output int e_wb,
                       output int e_m2r, output int e_mask, output int e_npc,
                       output int e_rr, output int e_br, output int e_alu,
                       output int e_s1, output int e_s2, output int e_imm);
    bit ok;
    bit alt;
    alt = ((b >> 5) & 1) == 1;
    ok = 1'b0;
    e_jal = 0; e_jalr = 0; e_wb = 0; e_m2r = 0; e_mask = 0; e_npc = 0;
    e_rr = 0; e_br = 0; e_alu = 0; e_s1 = 0; e_s2 = 0; e_imm = 0;
    if (o == 'b0000011) begin                       // load, R5 R11
      ok = (a != 3 && a != 6 && a != 7);
      if (ok) begin
        e_m2r = 1; e_rr = 2; e_imm = 1; e_s2 = 1;
        e_wb = (a == 0) ? 2 : (a == 1) ? 3 : (a == 2) ? 1 : (a == 4) ? 4 : 5;
      end
    end else if (o == 'b0100011) begin              // store, R3
      ok = (a <= 2);
      if (ok) begin
        e_mask = (1 << (1 << a)) - 1; e_rr = 3; e_imm = 2; e_s2 = 1;
      end
    end else if (o == 'b1100011) begin              // branch, R7
      ok = (a != 2 && a != 3);
      if (ok) begin
        e_br = (a < 2) ? a + 1 : a - 1; e_rr = 3; e_imm = 3;
      end
    end else if (o == 'b1100111) begin              // indirect jump, R2
      ok = (a == 0);
      if (ok) begin
        e_jalr = 1; e_npc = 1; e_wb = 1; e_rr = 2; e_imm = 1; e_s2 = 1;
      end
    end else if (o == 'b1101111) begin
      e_jal = 1; e_npc = 1; e_wb = 1; e_imm = 5; e_s2 = 1;
    end else if (o == 'b0110111) begin
      e_wb = 1; e_imm = 4; e_s2 = 1; e_alu = 10;
    end else if (o == 'b0010111) begin
      e_wb = 1; e_imm = 4; e_s2 = 1; e_s1 = 1;
    end else if (o == 'b0110011 || o == 'b0010011) begin   // R8
      bit reg_form;
      int ops[8];
      reg_form = (o == 'b0110011);
      if (reg_form) ok = (b == 0) || (b == 32 && (a == 0 || a == 5));
      else if (a == 1) ok = (b == 0);
      else if (a == 5) ok = (b == 0 || b == 32);
      else ok = 1'b1;
      if (ok) begin
        ops = '{0, 2, 3, 4, 5, 6, 8, 9};
        e_alu = ops[a];
        if (a == 0 && reg_form && alt) e_alu = 1;
        if (a == 5 && alt) e_alu = 7;
        e_wb = 1;
        e_rr = reg_form ? 3 : 2;
        e_imm = reg_form ? 0 : 1;
        e_s2 = reg_form ? 0 : ((a == 1 || a == 5) ? 2 : 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    op = '0; f3 = '0; f7 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, all-zero inputs give all-zero outputs
    chk({jal, jalr, wb, m2r, mask, npc, rr, br, alu, s1pc, s2, immf} == '0,
        "R1", "zero-input outputs", int'(alu), 0);
    for (int o = 0; o < 128; o++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 128; b++) begin
          int ej, ejr, ewb, em, emk, en, err, ebr, eal, es1, es2, eim;
          @(posedge clk);
          op = 7'(o); f3 = 3'(a); f7 = 7'(b);
          @(negedge clk);
          model(o, a, b, ej, ejr, ewb, em, emk, en, err, ebr, eal, es1, es2, eim);
          chk(int'(jal) == ej,    "R2",  "jal",        int'(jal), ej);
          chk(int'(jalr) == ejr,  "R2",  "jalr",       int'(jalr), ejr);
          chk(int'(mask) == emk,  "R3",  "store_mask", int'(mask), emk);
          chk(int'(m2r) == em,    "R4",  "mem_to_reg", int'(m2r), em);
          chk(int'(npc) == en,    "R4",  "load_npc",   int'(npc), en);
          chk(int'(wb) == ewb,    "R5",  "wb_mode",    int'(wb), ewb);
          chk(int'(rr) == err,    "R6",  "reg_read",   int'(rr), err);
          chk(int'(br) == ebr,    "R7",  "branch",     int'(br), ebr);
          chk(int'(alu) == eal,   "R8",  "alu_op",     int'(alu), eal);
          chk(int'(s1pc) == es1,  "R9",  "src1_pc",    int'(s1pc), es1);
          chk(int'(s2) == es2,    "R9",  "src2_sel",   int'(s2), es2);
          chk(int'(immf) == eim,  "R10", "imm_fmt",    int'(immf), eim);
          // R11: an illegal vector must leave every output at zero
          if (ewb == 0 && emk == 0 && ebr == 0)
            chk({jal, jalr, wb, m2r, mask, npc, rr, br, alu, s1pc, s2, immf} == '0,
                "R11", "inactive outputs", int'(wb), 0);
        end
      end
    end
    // R1: same inputs again give the same outputs
    @(posedge clk);
    op = 7'b1101111; f3 = 3'd0; f7 = 7'd0;
    @(negedge clk);
    chk(jal && npc && wb == 3'd1 && !m2r, "R1", "repeat jal", int'(wb), 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule